// File: doc/BRIEF.md
# Variable-Length Instruction Byte Parser

This block finds the boundaries of variable-length instructions in a stream of instruction bytes. It takes one byte per accepted handshake. For each byte it moves a small state machine through a fixed order of steps: legacy prefixes first, then an optional REX byte, then the opcode or a 0x0F escape, then the ModR/M byte, then the SIB byte, and last the displacement and immediate bytes. The length is counted as the bytes are parsed. It is never assumed to be a fixed width.

When the last byte of an instruction is accepted, the parser sets a one-cycle done pulse. With that pulse it presents the total length, the prefix flags, any REX bits, the opcode, the ModR/M and SIB bytes when they are present, and the displacement and immediate values. The supported opcode set is a fixed subset of the one-byte map and the escaped two-byte map, held in a small length-class table. If an instruction reaches 15 bytes without finishing, the parser reports an error and starts a new instruction on the next byte.

Top module: `ilp_parser`

## Requirements
- R1: After reset, `out_done` and `out_err` are low. `in_ready` is high from the first clock after reset is released.
- R2: The bytes F0, F2, F3, 66, 67, 2E, 36, 3E, 26, 64 and 65, seen before the opcode, are counted in the length and do not end the instruction. They set bits of `out_pfx` as follows: bit0 for F0, bit1 for F2, bit2 for F3, bit3 for 66, bit4 for 67, and bit5 for any of the six segment bytes.
- R3: When `mode64` is high, a byte 40..4F seen in the prefix step is a REX byte. It sets `out_rex_vld` and puts its low nibble on `out_rex`, and the next byte is always taken as the opcode or the escape. When `mode64` is low, 40..4F are one-byte opcodes.
- R4: A 0x0F byte in the opcode position is an escape. It sets `out_esc`, the following byte is looked up in the two-byte table, and that byte appears on `out_opcode`.
- R5: An opcode with no ModR/M byte and no immediate ends the instruction. For example, the segment pushes 06, 0E, 16 and 1E have length 1 plus the prefix bytes, and `out_modrm_vld` is low.
- R6: The one-byte table works as follows:
  - Bytes below 40 with low three bits 0..3 take a ModR/M byte. Low bits 4 give imm8, and low bits 5 give the operand-size immediate (immZ).
  - 70..7F, 6A, EB and B0..B7 give imm8.
  - 68, E8, E9 and B8..BF give immZ.
  - 69 and 81 take ModR/M plus immZ. 6B, 80, 82, 83 and C6 take ModR/M plus imm8. C7 takes ModR/M plus immZ. 84..8F take ModR/M only.
  - C2 gives imm16.
  - All other bytes take nothing.
- R7: The two-byte table works as follows: 80..8F give immZ with no ModR/M; 05, 0B, 31 and A2 take nothing; every other byte takes a ModR/M byte.
- R8: A SIB byte follows ModR/M exactly when mod (bits 7:6) is not 11 and rm (bits 2:0) is 100. It is reported on `out_sib` with `out_sib_vld`.
- R9: The displacement size is set as follows:
  - mod 01 gives 1 byte, and mod 10 gives 4 bytes.
  - mod 00 gives 4 bytes when rm is 101 without a SIB byte, or when the SIB base (bits 2:0) is 101 with a SIB byte.
  - Every other case gives 0 bytes.
- R10: The immediate size is 1 for imm8, 2 for imm16, and for immZ it is 2 when the 66 prefix is present and 4 otherwise. The displacement comes before the immediate. Both are assembled little-endian and zero-extended into `out_disp` and `out_imm`, and their sizes appear on `out_disp_len` and `out_imm_len`.
- R11: `out_done` is high for one cycle, in the cycle after the final byte is accepted, with `out_len` equal to the byte count. All outputs hold their values until the next done. The next byte starts a new instruction.
- R12: If the 15th byte of an instruction is accepted and the instruction is still incomplete, `out_err` pulses for one cycle and `out_done` stays low. The reported fields are left unchanged, and the next byte starts a new instruction. An instruction that completes on its 15th byte is reported normally.
- R13: Bytes presented while `in_valid` is low have no effect on parsing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode64 | input | 1 | Enables REX decoding of 40..4F |
| in_valid | input | 1 | Byte valid |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| out_done | output | 1 | One-cycle instruction-complete pulse |
| out_err | output | 1 | One-cycle over-length pulse |
| out_len | output | 4 | Total instruction length in bytes |
| out_pfx | output | 6 | Legacy prefix flags |
| out_rex_vld | output | 1 | REX byte present |
| out_rex | output | 4 | REX low nibble |
| out_esc | output | 1 | Two-byte map used |
| out_opcode | output | 8 | Opcode byte |
| out_modrm_vld | output | 1 | ModR/M present |
| out_modrm | output | 8 | ModR/M byte |
| out_sib_vld | output | 1 | SIB present |
| out_sib | output | 8 | SIB byte |
| out_disp_len | output | 3 | Displacement size in bytes |
| out_disp | output | 32 | Displacement value |
| out_imm_len | output | 3 | Immediate size in bytes |
| out_imm | output | 32 | Immediate value |

## Verification
The bench targets several boundary cases:
- A SIB byte whose base is 101 under mod 00, where a design that decodes only the rm field would drop four displacement bytes and merge them into the next instruction.
- An immZ opcode behind a 66 prefix, where a wrong size swallows or leaks two bytes.
- A byte 48 in each mode, and the pair of 14 prefixes plus an opcode (legal, length 15) against 15 prefixes (error). An off-by-one counter reports the wrong one of these two.
- Random instructions, built from fields with idle gaps and random values on the bus during those gaps. A parser that acts on invalid bytes, reports the displacement after the immediate, or stretches the done pulse shows a field mismatch.

// File: rtl/ilp_pkg.sv
package ilp_pkg;
  localparam int ILP_LW = 4;

  typedef enum logic [2:0] {
    ST_PFX, ST_REX, ST_ESC, ST_MODRM, ST_SIB, ST_DISP, ST_IMM
  } ilp_state_e;

  typedef enum logic [1:0] {IMM_NONE, IMM_B1, IMM_W2, IMM_Z} ilp_imm_e;

  typedef struct packed {
    logic [ILP_LW-1:0] len;
    logic [5:0]        pfx;
    logic              rex_vld;
    logic [3:0]        rex;
    logic              esc;
    logic [7:0]        opcode;
    logic              modrm_vld;
    logic [7:0]        modrm;
    logic              sib_vld;
    logic [7:0]        sib;
    logic [2:0]        disp_len;
    logic [31:0]       disp;
    logic [2:0]        imm_len;
    logic [31:0]       imm;
  } ilp_inst_t;

  // SIB present for a memory form whose rm selects the SIB escape
  function automatic logic sib_follows(input logic [7:0] modrm);
    return (modrm[7:6] != 2'b11) && (modrm[2:0] == 3'b100);
  endfunction

  function automatic logic [2:0] disp_bytes(input logic [7:0] modrm,
                                            input logic has_sib,
                                            input logic [7:0] sib);
    logic [2:0] base;
    base = has_sib ? sib[2:0] : modrm[2:0];
    case (modrm[7:6])
      2'b01:   return 3'd1;
      2'b10:   return 3'd4;
      2'b00:   return (base == 3'b101) ? 3'd4 : 3'd0;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] imm_bytes(input ilp_imm_e cls, input logic opsz);
    case (cls)
      IMM_B1:  return 3'd1;
      IMM_W2:  return 3'd2;
      IMM_Z:   return opsz ? 3'd2 : 3'd4;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/ilp_pfx_decode.sv
module ilp_pfx_decode (
  input  logic [7:0] byte_i,
  input  logic       mode64_i,
  output logic       legacy_o,
  output logic [5:0] bits_o,
  output logic       rex_o
);
  always_comb begin
    bits_o = 6'b0;
    case (byte_i)
      8'hF0: bits_o[0] = 1'b1;
      8'hF2: bits_o[1] = 1'b1;
      8'hF3: bits_o[2] = 1'b1;
      8'h66: bits_o[3] = 1'b1;
      8'h67: bits_o[4] = 1'b1;
      8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65: bits_o[5] = 1'b1;
      default: bits_o = 6'b0;
    endcase
    legacy_o = |bits_o;
    rex_o    = mode64_i && (byte_i[7:4] == 4'h4);
  end
endmodule

// File: rtl/ilp_len_table.sv
module ilp_len_table import ilp_pkg::*; (
  input  logic [7:0] op_i,
  input  logic       esc_i,
  output logic       modrm_o,
  output ilp_imm_e   imm_o
);
  always_comb begin
    modrm_o = 1'b0;
    imm_o   = IMM_NONE;
    if (esc_i) begin
      if (op_i[7:4] == 4'h8) imm_o = IMM_Z;
      else if (op_i == 8'h05 || op_i == 8'h0B || op_i == 8'h31 || op_i == 8'hA2) modrm_o = 1'b0;
      else modrm_o = 1'b1;
    end else if (op_i < 8'h40) begin
      case (op_i[2:0])
        3'd0, 3'd1, 3'd2, 3'd3: modrm_o = 1'b1;
        3'd4:    imm_o = IMM_B1;
        3'd5:    imm_o = IMM_Z;
        default: imm_o = IMM_NONE;
      endcase
    end else begin
      casez (op_i)
        8'b0111_????, 8'h6A, 8'hEB, 8'b1011_0???: imm_o = IMM_B1;
        8'h68, 8'hE8, 8'hE9, 8'b1011_1???:        imm_o = IMM_Z;
        8'h69, 8'h81, 8'hC7: begin modrm_o = 1'b1; imm_o = IMM_Z;  end
        8'h6B, 8'h80, 8'h82, 8'h83, 8'hC6: begin modrm_o = 1'b1; imm_o = IMM_B1; end
        8'b1000_01??, 8'b1000_1???: modrm_o = 1'b1;
        8'hC2:   imm_o = IMM_W2;
        default: imm_o = IMM_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ilp_parser.sv
module ilp_parser import ilp_pkg::*; #(
  parameter int MAX_LEN = 15
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mode64,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        out_done,
  output logic        out_err,
  output logic [3:0]  out_len,
  output logic [5:0]  out_pfx,
  output logic        out_rex_vld,
  output logic [3:0]  out_rex,
  output logic        out_esc,
  output logic [7:0]  out_opcode,
  output logic        out_modrm_vld,
  output logic [7:0]  out_modrm,
  output logic        out_sib_vld,
  output logic [7:0]  out_sib,
  output logic [2:0]  out_disp_len,
  output logic [31:0] out_disp,
  output logic [2:0]  out_imm_len,
  output logic [31:0] out_imm
);
  localparam logic [ILP_LW-1:0] LEN_LIMIT = ILP_LW'(MAX_LEN);

  ilp_state_e st_q, nst;
  ilp_inst_t  work_q, nxt, out_q;
  logic [2:0] fld_q, nfld;
  logic       ready_q, done_q, err_q;

  // named internal events
  logic accept, fin, ovf, take_op, tail, tail_imm;
  logic pf_legacy, pf_rex, tb_modrm;
  logic [5:0] pf_bits;
  ilp_imm_e tb_imm;

  assign accept = in_valid && ready_q;

  ilp_pfx_decode u_pfx (
    .byte_i(in_data), .mode64_i(mode64),
    .legacy_o(pf_legacy), .bits_o(pf_bits), .rex_o(pf_rex)
  );

  ilp_len_table u_tbl (
    .op_i(in_data), .esc_i(st_q == ST_ESC),
    .modrm_o(tb_modrm), .imm_o(tb_imm)
  );

  always_comb begin
    nxt      = work_q;
    nxt.len  = work_q.len + 1'b1;
    nst      = st_q;
    nfld     = fld_q;
    fin      = 1'b0;
    take_op  = 1'b0;
    tail     = 1'b0;
    tail_imm = 1'b0;
    case (st_q)
      ST_PFX: begin
        if (pf_legacy) nxt.pfx = work_q.pfx | pf_bits;
        else if (pf_rex) begin
          nxt.rex_vld = 1'b1;
          nxt.rex     = in_data[3:0];
          nst         = ST_REX;
        end else take_op = 1'b1;
      end
      ST_REX, ST_ESC: take_op = 1'b1;
      ST_MODRM: begin
        nxt.modrm_vld = 1'b1;
        nxt.modrm     = in_data;
        if (sib_follows(in_data)) nst = ST_SIB;
        else begin
          nxt.disp_len = disp_bytes(in_data, 1'b0, 8'h00);
          tail = 1'b1;
        end
      end
      ST_SIB: begin
        nxt.sib_vld  = 1'b1;
        nxt.sib      = in_data;
        nxt.disp_len = disp_bytes(work_q.modrm, 1'b1, in_data);
        tail = 1'b1;
      end
      ST_DISP: begin
        nxt.disp[{fld_q[1:0], 3'b000} +: 8] = in_data;
        nfld = fld_q + 3'd1;
        if (nfld == work_q.disp_len) begin
          nfld = 3'd0;
          tail_imm = 1'b1;
        end
      end
      ST_IMM: begin
        nxt.imm[{fld_q[1:0], 3'b000} +: 8] = in_data;
        nfld = fld_q + 3'd1;
        if (nfld == work_q.imm_len) begin
          nfld = 3'd0;
          fin = 1'b1;
        end
      end
      default: nst = ST_PFX;
    endcase
    if (take_op) begin
      if (st_q != ST_ESC && in_data == 8'h0F) begin
        nxt.esc = 1'b1;
        nst     = ST_ESC;
      end else begin
        nxt.opcode  = in_data;
        nxt.imm_len = imm_bytes(tb_imm, nxt.pfx[3]);
        if (tb_modrm) nst = ST_MODRM;
        else tail_imm = 1'b1;
      end
    end
    if (tail) begin
      if (nxt.disp_len != 3'd0) nst = ST_DISP;
      else tail_imm = 1'b1;
    end
    if (tail_imm) begin
      if (nxt.imm_len != 3'd0) nst = ST_IMM;
      else fin = 1'b1;
    end
    ovf = !fin && (nxt.len == LEN_LIMIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_PFX;
      work_q  <= '0;
      fld_q   <= '0;
      out_q   <= '0;
      ready_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      done_q  <= accept && fin;
      err_q   <= accept && ovf;
      if (accept) begin
        if (fin || ovf) begin
          work_q <= '0;
          st_q   <= ST_PFX;
          fld_q  <= '0;
          if (fin) out_q <= nxt;
        end else begin
          work_q <= nxt;
          st_q   <= nst;
          fld_q  <= nfld;
        end
      end
    end
  end

  assign in_ready      = ready_q;
  assign out_done      = done_q;
  assign out_err       = err_q;
  assign out_len       = out_q.len;
  assign out_pfx       = out_q.pfx;
  assign out_rex_vld   = out_q.rex_vld;
  assign out_rex       = out_q.rex;
  assign out_esc       = out_q.esc;
  assign out_opcode    = out_q.opcode;
  assign out_modrm_vld = out_q.modrm_vld;
  assign out_modrm     = out_q.modrm;
  assign out_sib_vld   = out_q.sib_vld;
  assign out_sib       = out_q.sib;
  assign out_disp_len  = out_q.disp_len;
  assign out_disp      = out_q.disp;
  assign out_imm_len   = out_q.imm_len;
  assign out_imm       = out_q.imm;

  assert_done_err_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(out_done && out_err));
  assert_err_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    out_err |=> !out_err);
  assert_len_bound_R11: assert property (@(posedge clk) disable iff (rst)
    out_done |-> (out_len != 4'd0) && (out_len <= LEN_LIMIT));
  assert_done_resync_R11: assert property (@(posedge clk) disable iff (rst)
    out_done |-> st_q == ST_PFX);
  assert_sib_rule_R8: assert property (@(posedge clk) disable iff (rst)
    (out_done && out_sib_vld) |-> out_modrm_vld && out_modrm[7:6] != 2'b11 && out_modrm[2:0] == 3'b100);
  assert_disp_mod1_R9: assert property (@(posedge clk) disable iff (rst)
    (out_done && out_modrm_vld && out_modrm[7:6] == 2'b01) |-> out_disp_len == 3'd1);
  assert_rex_mode_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && st_q == ST_PFX && pf_rex) |-> mode64 && in_data[7:4] == 4'h4);
  assert_idle_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(st_q) && $stable(work_q));
endmodule

// File: tb/ilp_parser_tb.sv
module ilp_parser_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode64 = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_done, out_err, out_rex_vld, out_esc, out_modrm_vld, out_sib_vld;
  logic [3:0] out_len, out_rex;
  logic [5:0] out_pfx;
  logic [7:0] out_opcode, out_modrm, out_sib;
  logic [2:0] out_disp_len, out_imm_len;
  logic [31:0] out_disp, out_imm;

  always #5 clk = ~clk;

  ilp_parser dut_i (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0] q_b[16];
  int q_n;
  int e_len, e_pfx, e_rexv, e_rex, e_esc, e_op, e_mv, e_m, e_sv, e_s, e_dl, e_d, e_il, e_i;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void tb_class(input logic [7:0] o, input bit esc, output bit m, output int imm);
    m = 0; imm = 0; // imm: 0,1,2 bytes, 9 means operand-size dependent
    if (esc) begin
      if (o >= 8'h80 && o <= 8'h8F) imm = 9;
      else if (!(o == 8'h05 || o == 8'h0B || o == 8'h31 || o == 8'hA2)) m = 1;
    end else if (o < 8'h40) begin
      m = (o % 8) < 4;
      imm = (o % 8 == 4) ? 1 : ((o % 8 == 5) ? 9 : 0);
    end else if ((o >= 8'h70 && o <= 8'h7F) || (o >= 8'hB0 && o <= 8'hB7)) imm = 1;
    else if (o >= 8'hB8 && o <= 8'hBF) imm = 9;
    else if (o >= 8'h84 && o <= 8'h8F) m = 1;
    else case (o)
      8'h68, 8'hE8, 8'hE9: imm = 9;
      8'h6A, 8'hEB: imm = 1;
      8'h69, 8'h81, 8'hC7: begin m = 1; imm = 9; end
      8'h6B, 8'h80, 8'h82, 8'h83, 8'hC6: begin m = 1; imm = 1; end
      8'hC2: imm = 2;
      default: imm = 0;
    endcase
  endfunction

  function automatic int tb_disp(input logic [7:0] m, input bit has_s, input logic [7:0] s);
    if (m[7:6] == 2'b01) return 1;
    if (m[7:6] == 2'b10) return 4;
    if (m[7:6] == 2'b00 && (has_s ? s[2:0] : m[2:0]) == 3'b101) return 4;
    return 0;
  endfunction

  function automatic int tb_pfx_bit(input logic [7:0] b);
    case (b)
      8'hF0: return 0; 8'hF2: return 1; 8'hF3: return 2;
      8'h66: return 3; 8'h67: return 4;
      8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65: return 5;
      default: return -1;
    endcase
  endfunction

  task automatic set_exp(input int len, pfx, rexv, rex, esc, op, mv, m, sv, s, dl, d, il, i);
    e_len = len; e_pfx = pfx; e_rexv = rexv; e_rex = rex; e_esc = esc; e_op = op;
    e_mv = mv; e_m = m; e_sv = sv; e_s = s; e_dl = dl; e_d = d; e_il = il; e_i = i;
  endtask

  // feed q_b[0..q_n-1], sample one negedge after the final accept edge
  task automatic feed(input bit gaps);
    bit early = 0;
    for (int k = 0; k < q_n; k++) begin
      if (gaps) begin
        int g = $urandom_range(0, 2);
        for (int j = 0; j < g; j++) begin
          @(negedge clk);
          if (k > 0 && out_done) early = 1;
          in_valid = 1'b0; in_data = 8'($urandom);
        end
      end
      @(negedge clk);
      if (k > 0 && out_done) early = 1;
      in_valid = 1'b1; in_data = q_b[k];
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_data = 8'($urandom);
    chk("R11 no early done", 32'(early), 32'd0);
  endtask

  task automatic check_inst(input string tag);
    int held;
    chk({tag, " R11 done"}, 32'(out_done), 32'd1);
    chk({tag, " R11 len"}, 32'(out_len), 32'(e_len));
    chk({tag, " R2 pfx"}, 32'(out_pfx), 32'(e_pfx));
    chk({tag, " R3 rex"}, {27'd0, out_rex_vld, out_rex}, 32'((e_rexv << 4) | e_rex));
    chk({tag, " R4 esc/op"}, {23'd0, out_esc, out_opcode}, 32'((e_esc << 8) | e_op));
    chk({tag, " R6 modrm"}, {23'd0, out_modrm_vld, out_modrm}, 32'((e_mv << 8) | e_m));
    chk({tag, " R8 sib"}, {23'd0, out_sib_vld, out_sib}, 32'((e_sv << 8) | e_s));
    chk({tag, " R9 disp_len"}, 32'(out_disp_len), 32'(e_dl));
    chk({tag, " R10 disp"}, out_disp, 32'(e_d));
    chk({tag, " R10 imm_len"}, 32'(out_imm_len), 32'(e_il));
    chk({tag, " R10 imm"}, out_imm, 32'(e_i));
    held = out_len;
    @(negedge clk);
    chk({tag, " R11 pulse"}, 32'(out_done), 32'd0);
    chk({tag, " R11 hold"}, 32'(out_len), 32'(held));
  endtask

  task automatic load(input logic [7:0] b0, b1, b2, b3, b4, b5, b6, b7, b8, b9, input int n);
    q_b[0] = b0; q_b[1] = b1; q_b[2] = b2; q_b[3] = b3; q_b[4] = b4;
    q_b[5] = b5; q_b[6] = b6; q_b[7] = b7; q_b[8] = b8; q_b[9] = b9; q_n = n;
  endtask

  task automatic rand_inst();
    int np, pf, il, dl, n;
    bit m, sv, esc;
    logic [7:0] op, mr, sb, b;
    logic [31:0] dv, iv;
    mode64 = $urandom_range(0, 1);
    n = 0; pf = 0;
    np = $urandom_range(0, 3);
    for (int k = 0; k < np; k++) begin
      case ($urandom_range(0, 10))
        0: b = 8'hF0; 1: b = 8'hF2; 2: b = 8'hF3; 3: b = 8'h66; 4: b = 8'h67;
        5: b = 8'h2E; 6: b = 8'h36; 7: b = 8'h3E; 8: b = 8'h26; 9: b = 8'h64;
        default: b = 8'h65;
      endcase
      pf |= 1 << tb_pfx_bit(b);
      q_b[n++] = b;
    end
    e_rexv = 0; e_rex = 0;
    if (mode64 && $urandom_range(0, 1) == 1) begin
      e_rex = $urandom_range(0, 15); e_rexv = 1;
      q_b[n++] = 8'h40 | 8'(e_rex);
    end
    esc = ($urandom_range(0, 3) == 0);
    if (esc) q_b[n++] = 8'h0F;
    do op = 8'($urandom);
    while (!esc && (tb_pfx_bit(op) >= 0 || op == 8'h0F || (mode64 && op[7:4] == 4'h4)));
    q_b[n++] = op;
    tb_class(op, esc, m, il);
    if (il == 9) il = ((pf >> 3) & 1) ? 2 : 4;
    mr = 8'($urandom); sb = 8'($urandom); sv = 0; dl = 0;
    if (m) begin
      q_b[n++] = mr;
      sv = (mr[7:6] != 2'b11 && mr[2:0] == 3'b100);
      if (sv) q_b[n++] = sb;
      dl = tb_disp(mr, sv, sb);
    end
    dv = 0; iv = 0;
    for (int k = 0; k < dl; k++) begin b = 8'($urandom); dv |= 32'(b) << (8 * k); q_b[n++] = b; end
    for (int k = 0; k < il; k++) begin b = 8'($urandom); iv |= 32'(b) << (8 * k); q_b[n++] = b; end
    q_n = n;
    set_exp(n, pf, e_rexv, e_rex, esc, op, m, m ? mr : 0, sv, sv ? sb : 0, dl, dv, il, iv);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 done low", 32'(out_done), 32'd0);
    chk("R1 err low", 32'(out_err), 32'd0);
    chk("R1 ready", 32'(in_ready), 32'd1);

    load(8'h90, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    set_exp(1, 0, 0, 0, 0, 8'h90, 0, 0, 0, 0, 0, 0, 0, 0);
    feed(0); check_inst("nop R5");

    load(8'h06, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    set_exp(1, 0, 0, 0, 0, 8'h06, 0, 0, 0, 0, 0, 0, 0, 0);
    feed(0); check_inst("segpush R5");

    load(8'h66, 8'h81, 8'hC0, 8'h34, 8'h12, 0, 0, 0, 0, 0, 5);
    set_exp(5, 8, 0, 0, 0, 8'h81, 1, 8'hC0, 0, 0, 0, 0, 2, 32'h1234);
    feed(0); check_inst("opsz immZ R10");

    load(8'h8B, 8'h04, 8'h25, 8'h78, 8'h56, 8'h34, 8'h12, 0, 0, 0, 7);
    set_exp(7, 0, 0, 0, 0, 8'h8B, 1, 8'h04, 1, 8'h25, 4, 32'h12345678, 0, 0);
    feed(0); check_inst("sib base5 R9");

    load(8'h0F, 8'h84, 8'h11, 8'h22, 8'h33, 8'h44, 0, 0, 0, 0, 6);
    set_exp(6, 0, 0, 0, 1, 8'h84, 0, 0, 0, 0, 0, 0, 4, 32'h44332211);
    feed(0); check_inst("escape R4 R7");

    load(8'hC7, 8'h05, 8'h01, 8'h02, 8'h03, 8'h04, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 10);
    set_exp(10, 0, 0, 0, 0, 8'hC7, 1, 8'h05, 0, 0, 4, 32'h04030201, 4, 32'h0D0C0B0A);
    feed(1); check_inst("disp then imm R10");

    load(8'h83, 8'h45, 8'hF8, 8'h07, 0, 0, 0, 0, 0, 0, 4);
    set_exp(4, 0, 0, 0, 0, 8'h83, 1, 8'h45, 0, 0, 1, 32'hF8, 1, 32'h07);
    feed(0); check_inst("mod1 R9");

    load(8'hC2, 8'h10, 8'h00, 0, 0, 0, 0, 0, 0, 0, 3);
    set_exp(3, 0, 0, 0, 0, 8'hC2, 0, 0, 0, 0, 0, 0, 2, 32'h0010);
    feed(0); check_inst("imm16 R6");

    mode64 = 1'b0;
    load(8'h48, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    set_exp(1, 0, 0, 0, 0, 8'h48, 0, 0, 0, 0, 0, 0, 0, 0);
    feed(0); check_inst("no rex mode R3");

    mode64 = 1'b1;
    load(8'h48, 8'h89, 8'h04, 8'h24, 0, 0, 0, 0, 0, 0, 4);
    set_exp(4, 0, 1, 8, 0, 8'h89, 1, 8'h04, 1, 8'h24, 0, 0, 0, 0);
    feed(1); check_inst("rex sib R3 R8");
    mode64 = 1'b0;

    // 14 prefixes + opcode = 15 bytes, legal
    for (int k = 0; k < 14; k++) q_b[k] = 8'hF3;
    q_b[14] = 8'h90; q_n = 15;
    set_exp(15, 4, 0, 0, 0, 8'h90, 0, 0, 0, 0, 0, 0, 0, 0);
    feed(0); check_inst("len15 R12");

    // 15 prefixes: over-length
    prev = out_len;
    for (int k = 0; k < 15; k++) q_b[k] = 8'h66;
    q_n = 15;
    feed(0);
    chk("R12 err", 32'(out_err), 32'd1);
    chk("R12 no done", 32'(out_done), 32'd0);
    chk("R12 fields held", 32'(out_len), 32'(prev));
    @(negedge clk);
    chk("R12 err pulse", 32'(out_err), 32'd0);
    load(8'h90, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    set_exp(1, 0, 0, 0, 0, 8'h90, 0, 0, 0, 0, 0, 0, 0, 0);
    feed(0); check_inst("resync R12");

    void'($urandom(32'd12345));
    for (int t = 0; t < 400; t++) begin
      rand_inst();
      feed(1);
      check_inst("rand");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule